// File: doc/BRIEF.md
# Bank-Aware Memory Request Scheduler

This block sits in front of a banked, double-rate data memory and decides which pending access goes out in each issue slot. Four requesters each push accesses into a private queue; every access names a segment address and whether it is a read or a write. Because one segment transfer occupies the memory bus for four clock cycles, the block makes one decision every four cycles.

The decision walks the queues in round-robin order, starting just after the queue served last. It skips any queue whose oldest access targets a bank used by one of the three most recent slots. A port whose head is stalled on a busy bank therefore never holds up accesses queued on other ports. When no queue has an eligible head, the slot carries a no-operation (deselect) command. That empty slot enters the history as "no bank", so a busy bank frees up after three slots even when traffic stops. Bank timing, refresh and the data path are handled elsewhere; bank occupancy is modelled only through this short history.

Top module: `bank_aware_sched`

## Requirements
- R1: `cmd_start` pulses for exactly one cycle per issue slot of 4 clock cycles. The first pulse is in the cycle after the first rising edge with reset released, and later pulses follow every 4 cycles.
- R2: Accesses from one port are issued in the order they were pushed. A port whose head is blocked does not delay eligible accesses of other ports.
- R3: The bank of an access is bits [2:0] of its segment address. An access is never issued to a bank that was issued in any of the previous three slots.
- R4: The search for an eligible head starts at the port after the one most recently granted (port 0 after reset). The first eligible port in ascending ring order wins, and `cmd_port` reports it.
- R5: The same port may be granted in consecutive slots when every other port is empty or blocked.
- R6: When no head is eligible, the slot carries `cmd_op` = 0 with `cmd_addr` = 0 and `cmd_port` = 0, and the round-robin start point does not move. Such a slot occupies a history place with no bank.
- R7: `in_full[p]` is high while queue p holds 4 accesses. A push to a full queue is dropped.
- R8: An issued access carries `cmd_op` = 1 for a read (`in_write` low at push) and `cmd_op` = 2 for a write, and `cmd_addr` equal to the pushed segment address.
- R9: During reset, `cmd_start`, `cmd_op`, `cmd_addr`, `cmd_port` and `in_full` are all zero, and all queues and history are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 4 | Per-port push strobe |
| in_addr | input | 48 | Per-port segment address, port p in bits [12p+11:12p] |
| in_write | input | 4 | Per-port access kind, 1 = write |
| in_full | output | 4 | Per-port queue full |
| cmd_start | output | 1 | One-cycle pulse marking a new slot's command |
| cmd_op | output | 2 | 0 deselect, 1 read, 2 write |
| cmd_addr | output | 12 | Segment address of the issued access |
| cmd_port | output | 2 | Port the issued access came from |

## Verification
A corrupted bank history shows up at the next slot boundary. Either an access is issued into a bank used within the last three slots, or a deselect appears although an eligible head was waiting; both are visible on `cmd_addr` and `cmd_op` within four cycles. A wrong round-robin pointer shows up as a different `cmd_port` as soon as two ports are eligible together. A queue pointer error shows up as an address issued out of push order, or as `in_full` disagreeing with the number of accepted pushes in the same cycle. The bench keeps its own model of every queue, the history and the pointer, and compares all outputs every cycle, so any such divergence is reported within one slot.

// File: rtl/bank_sched_pkg.sv
package bank_sched_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } mem_op_e;

  // bank index: low address bits
  function automatic int unsigned bank_sel(input int unsigned seg, input int unsigned nbits);
    return seg % (32'd1 << nbits);
  endfunction

  // next position on a ring of n entries
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
    return (idx + 1) % n;
  endfunction

endpackage

// File: rtl/seg_fifo.sv
module seg_fifo #(
  parameter int DW    = 13,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full
);
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);

  logic [DW-1:0]   mem [DEPTH];
  logic [PTRW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0]   count;
  logic            push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [PTRW-1:0] bump(input logic [PTRW-1:0] p);
    return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  // a push into a full queue with no pop leaves the occupancy unchanged
  assert_drop_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(count));

  // the scheduler only pops a queue that holds an access
  assert_pop_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/bank_hist.sv
module bank_hist #(
  parameter int BW     = 3,
  parameter int HIST   = 3,
  parameter int NPROBE = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic                 ins_valid,
  input  logic [BW-1:0]        ins_bank,
  input  logic [NPROBE*BW-1:0] probe_bank,
  output logic [NPROBE-1:0]    probe_busy
);
  logic [HIST-1:0] hv;
  logic [BW-1:0]   hb [HIST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv <= '0;
      for (int i = 0; i < HIST; i++) hb[i] <= '0;
    end else if (shift_en) begin
      for (int i = HIST - 1; i > 0; i--) begin
        hv[i] <= hv[i-1];
        hb[i] <= hb[i-1];
      end
      hv[0] <= ins_valid;
      hb[0] <= ins_bank;
    end
  end

  always_comb begin
    probe_busy = '0;
    for (int p = 0; p < NPROBE; p++)
      for (int i = 0; i < HIST; i++)
        if (hv[i] && (hb[i] == probe_bank[p*BW +: BW])) probe_busy[p] = 1'b1;
  end

  // a granted bank enters the newest history place
  assert_entry_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && ins_valid) |=> (hv[0] && (hb[0] == $past(ins_bank))));

  // a deselect slot occupies the newest place with no bank
  assert_idle_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !ins_valid) |=> !hv[0]);

endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [PW-1:0] ptr,
  output logic          gnt_valid,
  output logic [PW-1:0] gnt_idx
);
  // walk the ring backwards so the lowest offset from ptr is assigned last
  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int off = N - 1; off >= 0; off--) begin
      int unsigned cand;
      cand = (int'(ptr) + off) % N;
      if (req[cand]) begin
        gnt_valid = 1'b1;
        gnt_idx   = PW'(cand);
      end
    end
  end
endmodule

// File: rtl/bank_aware_sched.sv
module bank_aware_sched
  import bank_sched_pkg::*;
#(
  parameter int NPORT      = 4,
  parameter int AW         = 12,
  parameter int BANK_BITS  = 3,
  parameter int FIFO_DEPTH = 4,
  parameter int HIST_LEN   = 3,
  parameter int SLOT_CYC   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPORT-1:0]      in_valid,
  input  logic [NPORT*AW-1:0]   in_addr,
  input  logic [NPORT-1:0]      in_write,
  output logic [NPORT-1:0]      in_full,
  output logic                  cmd_start,
  output logic [1:0]            cmd_op,
  output logic [AW-1:0]         cmd_addr,
  output logic [$clog2(NPORT)-1:0] cmd_port
);
  localparam int PW  = $clog2(NPORT);
  localparam int BW  = BANK_BITS;
  localparam int EW  = AW + 1;
  localparam int SCW = $clog2(SLOT_CYC);

  // named internal events
  logic [SCW-1:0]      slot_cnt;
  logic                issue_en;
  logic [EW-1:0]       head [NPORT];
  logic [NPORT-1:0]    empty;
  logic [NPORT*BW-1:0] head_bank;
  logic [NPORT-1:0]    busy;
  logic [NPORT-1:0]    elig;
  logic [NPORT-1:0]    pop;
  logic                gnt_valid;
  logic [PW-1:0]       gnt_idx;
  logic [PW-1:0]       rr_ptr;
  logic [EW-1:0]       sel_head;
  logic [BW-1:0]       sel_bank;
  mem_op_e             op_q;

  assign issue_en = (slot_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_cnt <= '0;
    else        slot_cnt <= (slot_cnt == SCW'(SLOT_CYC - 1)) ? '0 : slot_cnt + 1'b1;
  end

  // one queue per port
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    seg_fifo #(.DW(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (in_valid[p]),
      .din   ({in_write[p], in_addr[p*AW +: AW]}),
      .pop   (pop[p]),
      .dout  (head[p]),
      .empty (empty[p]),
      .full  (in_full[p])
    );
    assign head_bank[p*BW +: BW] = BW'(bank_sel(32'(head[p][AW-1:0]), BW));
    assign pop[p] = issue_en && gnt_valid && (gnt_idx == PW'(p));
  end

  assign sel_head = head[gnt_idx];
  assign sel_bank = head_bank[gnt_idx*BW +: BW];

  bank_hist #(.BW(BW), .HIST(HIST_LEN), .NPROBE(NPORT)) u_hist (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en   (issue_en),
    .ins_valid  (gnt_valid),
    .ins_bank   (sel_bank),
    .probe_bank (head_bank),
    .probe_busy (busy)
  );

  assign elig = ~empty & ~busy;

  rr_pick #(.N(NPORT), .PW(PW)) u_pick (
    .req       (elig),
    .ptr       (rr_ptr),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_ptr    <= '0;
      cmd_start <= 1'b0;
      op_q      <= OP_IDLE;
      cmd_addr  <= '0;
      cmd_port  <= '0;
    end else begin
      cmd_start <= issue_en;
      if (issue_en) begin
        if (gnt_valid) begin
          rr_ptr   <= PW'(ring_next(32'(gnt_idx), NPORT));
          op_q     <= sel_head[AW] ? OP_WR : OP_RD;
          cmd_addr <= sel_head[AW-1:0];
          cmd_port <= gnt_idx;
        end else begin
          op_q     <= OP_IDLE;
          cmd_addr <= '0;
          cmd_port <= '0;
        end
      end
    end
  end

  assign cmd_op = op_q;

  // slot strobe never lasts two cycles
  assert_slot_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !cmd_start);

  // a grant goes to a queue that holds an access outside the busy banks
  assert_grant_free_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_en && gnt_valid) |-> (!busy[gnt_idx] && !empty[gnt_idx]));

  // the port at the pointer wins whenever it is eligible
  assert_ptr_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_en && elig[rr_ptr]) |-> (gnt_valid && (gnt_idx == rr_ptr)));

  // nothing eligible: a deselect goes out and the pointer holds
  assert_idle_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_en && (elig == '0)) |=> (cmd_start && (cmd_op == OP_IDLE)));

  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_en && !gnt_valid) |=> $stable(rr_ptr));

  // at most one queue is popped per slot
  assert_single_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop));

endmodule

// File: tb/bank_aware_sched_tb_top.sv
module bank_aware_sched_tb_top;
  localparam int NP    = 4;
  localparam int AW    = 12;
  localparam int DEPTH = 4;
  localparam int SLOT  = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic [NP-1:0]     in_valid, in_write, in_full;
  logic [NP*AW-1:0]  in_addr;
  logic              cmd_start;
  logic [1:0]        cmd_op;
  logic [AW-1:0]     cmd_addr;
  logic [1:0]        cmd_port;

  bank_aware_sched #(.NPORT(NP), .AW(AW), .BANK_BITS(3), .FIFO_DEPTH(DEPTH),
                     .HIST_LEN(3), .SLOT_CYC(SLOT)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .in_write(in_write), .in_full(in_full), .cmd_start(cmd_start),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_port(cmd_port));

  int    n_checks = 0;
  int    n_err    = 0;
  bit    chk_en   = 1'b0;
  bit    done     = 1'b0;
  string phase_tag = "R9 reset";

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s [%s]: got %0d expected %0d", req, phase_tag, act, exp);
    end
  endtask

  // reference model: queues, three-slot bank history, ring pointer, slot phase
  int mq_addr [NP][DEPTH];
  bit mq_wr   [NP][DEPTH];
  int mcnt [NP];
  int mrd  [NP];
  int hb   [3];
  int mrr, mph;
  bit e_start;
  int e_op, e_addr, e_port;

  always @(posedge clk) begin : model
    bit acc [NP];
    int ch, cb, p, b, idx;
    if (!rst_n) begin
      for (int q = 0; q < NP; q++) begin mcnt[q] = 0; mrd[q] = 0; end
      for (int i = 0; i < 3; i++) hb[i] = -1;
      mrr = 0; mph = 0; e_start = 0; e_op = 0; e_addr = 0; e_port = 0;
    end else begin
      for (int q = 0; q < NP; q++) acc[q] = in_valid[q] && (mcnt[q] < DEPTH);
      if (mph == 0) begin
        ch = -1; cb = -1;
        for (int k = 0; k < NP; k++) begin
          p = (mrr + k) % NP;
          if (ch < 0 && mcnt[p] > 0) begin
            b = mq_addr[p][mrd[p]] % 8;
            if (b != hb[0] && b != hb[1] && b != hb[2]) begin ch = p; cb = b; end
          end
        end
        hb[2] = hb[1]; hb[1] = hb[0]; hb[0] = cb;
        e_start = 1;
        if (ch >= 0) begin
          e_op   = mq_wr[ch][mrd[ch]] ? 2 : 1;
          e_addr = mq_addr[ch][mrd[ch]];
          e_port = ch;
          mrd[ch] = (mrd[ch] + 1) % DEPTH;
          mcnt[ch]--;
          mrr = (ch + 1) % NP;
        end else begin
          e_op = 0; e_addr = 0; e_port = 0;
        end
      end else begin
        e_start = 0;
      end
      for (int q = 0; q < NP; q++) begin
        if (acc[q]) begin
          idx = (mrd[q] + mcnt[q]) % DEPTH;
          mq_addr[q][idx] = int'(in_addr[q*AW +: AW]);
          mq_wr[q][idx]   = in_write[q];
          mcnt[q]++;
        end
      end
      mph = (mph + 1) % SLOT;
    end
  end

  always @(negedge clk) begin
    if (rst_n && chk_en) begin
      chk("R1 slot strobe", int'(cmd_start), int'(e_start));
      if (e_start) begin
        chk((e_op == 0) ? "R6 deselect op" : "R8 op code", int'(cmd_op), e_op);
        chk("R4 granted port", int'(cmd_port), e_port);
        chk("R2 R3 issued address", int'(cmd_addr), e_addr);
      end
      for (int q = 0; q < NP; q++)
        chk("R7 full flag", int'(in_full[q]), (mcnt[q] == DEPTH) ? 1 : 0);
    end
  end

  // {valid[3:0], write[3:0], addr3, addr2, addr1, addr0, idle cycles}
  localparam logic [59:0] VEC [14] = '{
    60'hF_5_013_022_031_040_2,
    60'hF_A_108_210_318_420_1,
    60'h3_1_000_000_005_00D_3,
    60'hC_C_0F7_1F7_000_000_0,
    60'h1_0_000_000_000_002_5,
    60'h2_0_000_000_00A_000_0,
    60'h4_4_000_012_000_000_7,
    60'h8_0_3FF_000_000_000_2,
    60'hF_F_019_011_009_001_3,
    60'h5_4_000_06E_000_06E_1,
    60'hA_2_123_000_124_000_0,
    60'hF_0_0AB_0AC_0AD_0AE_6,
    60'hF_3_044_04C_054_05C_0,
    60'h0_0_000_000_000_000_F
  };

  task automatic apply_vec(input logic [59:0] v);
    @(negedge clk);
    in_valid = v[59:56];
    in_write = v[55:52];
    in_addr  = v[51:4];
    @(negedge clk);
    in_valid = '0;
    repeat (int'(v[3:0])) @(negedge clk);
  endtask

  task automatic wait_start();
    do @(negedge clk); while (cmd_start !== 1'b1);
  endtask

  // n back-to-back pushes to one port, address stepping by step
  task automatic push_burst(input int port, input int base, input int step,
                            input int n, input bit wr);
    for (int i = 0; i < n; i++) begin
      in_valid = '0;
      in_valid[port] = 1'b1;
      in_write[port] = wr;
      in_addr[port*AW +: AW] = AW'(base + step * i);
      @(negedge clk);
    end
    in_valid = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = '0; in_write = '0; in_addr = '0;
    repeat (3) @(negedge clk);
    phase_tag = "R9 reset";
    chk("R9 start low", int'(cmd_start), 0);
    chk("R9 op zero", int'(cmd_op), 0);
    chk("R9 addr zero", int'(cmd_addr), 0);
    chk("R9 port zero", int'(cmd_port), 0);
    chk("R9 full low", int'(in_full), 0);
    #1 rst_n = 1'b1;
    chk_en = 1'b1;

    phase_tag = "R3 R4 R8 table";
    for (int i = 0; i < 14; i++) apply_vec(VEC[i]);
    idle(60);

    // bank 0 held busy by port 1 while port 0 fills with bank-0 accesses
    phase_tag = "R3 R7 busy bank fill";
    wait_start();
    push_burst(1, 12'h010, 0, 1, 1'b0);
    wait_start();
    push_burst(0, 12'h008, 12'h010, 6, 1'b1);
    chk("R7 queue full after burst", int'(in_full[0]), 1);
    idle(60);

    // only port 2 holds work: it is served slot after slot
    phase_tag = "R5 same port back to back";
    wait_start();
    push_burst(2, 12'h101, 1, 3, 1'b0);
    idle(24);

    // order within a port, with another port blocked on a shared bank
    phase_tag = "R2 order and no blocking";
    wait_start();
    push_burst(3, 12'h206, 12'h001, 3, 1'b1);
    push_burst(1, 12'h30E, 0, 1, 1'b0);
    idle(32);

    // deselects age the history so a repeated bank issues again
    phase_tag = "R6 history aging";
    wait_start();
    push_burst(0, 12'h024, 0, 1, 1'b0);
    wait_start();
    push_burst(1, 12'h02C, 0, 1, 1'b1);
    idle(32);

    // reset with work queued clears everything
    phase_tag = "R9 reset with queued work";
    push_burst(3, 12'h055, 8, 4, 1'b0);
    #1 rst_n = 1'b0;
    @(negedge clk);
    chk("R9 full cleared", int'(in_full), 0);
    chk("R9 start cleared", int'(cmd_start), 0);
    chk("R9 op cleared", int'(cmd_op), 0);
    chk("R9 addr cleared", int'(cmd_addr), 0);
    #1 rst_n = 1'b1;
    idle(24);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

endmodule